// File: doc/BRIEF.md
# Dual-Queue Conversion Command Scheduler

This block takes entries from one shared list of conversion commands and hands them out for two command queues. Each queue has its own trigger input and its own window in the list, given by a first index and a last index. A high-priority queue (queue 1) always wins over a low-priority queue (queue 2). The scheduler gives one command index at a time to an external converter. It moves on to the next index when the converter returns a one-cycle done pulse. The converter, or the command memory beside it, also returns the pause flag of the command being issued. A command whose pause flag is set closes a sub-queue. The queue then waits for its next trigger and continues from the following command.

A queue 1 trigger that arrives while queue 2 is converting does three things: it drives an abort pulse to the converter, it suspends queue 2, and it starts queue 1. Once queue 1 finishes or pauses, queue 2 carries on by itself. A policy input chooses whether queue 2 starts its window again or repeats the aborted command. Queue 2 triggers that cannot be served at once are recorded as pending. Triggers that arrive while one is already outstanding set a sticky overrun flag.

Top module: `cqs_sched`

## Requirements
- R1: After reset both statuses read idle (code 0), both overrun flags are 0, and `cmd_valid` and `cmd_abort` are 0. Status codes are: idle 0, active 1, paused 2, suspended 3, trigger-pending 4, complete 5.
- R2: A trigger to an idle or complete queue makes it active from the next cycle with `cmd_idx` equal to its first index. Each `conv_done` moves `cmd_idx` to the next index. `cmd_valid` is 1 whenever a queue is active.
- R3: When `conv_done` arrives for the command at a queue's last index, that queue becomes complete (5) and stops issuing. A later trigger starts it again from its first index.
- R4: When `conv_done` arrives for a command issued with `cmd_pause`=1 that is not the last index, the queue becomes paused (2). Its next trigger continues from the following index.
- R5: A queue 2 trigger while queue 1 is active sets queue 2 to trigger-pending (4). Queue 2 becomes active one cycle after queue 1 leaves the active state.
- R6: When both queues are triggered in the same cycle, queue 1 becomes active and queue 2 becomes trigger-pending.
- R7: The queue 2 overrun flag is set by a queue 2 trigger while queue 2 is pending, suspended or active. The queue 1 overrun flag is set by a queue 1 trigger while queue 1 is active. Both flags stay set until reset.
- R8: A queue 1 trigger while queue 2 is active raises `cmd_abort` in that same cycle for exactly one cycle. Queue 2 becomes suspended (3), and a `conv_done` in that cycle is ignored.
- R9: `q2_resume_cur` is sampled at the abort. A value of 0 makes queue 2 resume at its first index. A value of 1 makes it resume at the aborted index.
- R10: A suspended queue 2 becomes active again, with no new trigger, one cycle after queue 1 leaves the active state.
- R11: At most one queue is active at a time. `cmd_idx` shows the active queue's current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q1_trig | input | 1 | Queue 1 trigger event |
| q2_trig | input | 1 | Queue 2 trigger event |
| q1_first | input | IDX_W | Queue 1 first command index |
| q1_last | input | IDX_W | Queue 1 last command index |
| q2_first | input | IDX_W | Queue 2 first command index |
| q2_last | input | IDX_W | Queue 2 last command index |
| q2_resume_cur | input | 1 | Resume policy: 0 restart, 1 repeat aborted command |
| cmd_pause | input | 1 | Pause flag of the command at `cmd_idx` |
| conv_done | input | 1 | Converter finished the issued command |
| cmd_valid | output | 1 | A command is being issued |
| cmd_idx | output | IDX_W | Index of the issued command |
| cmd_abort | output | 1 | Abort the current conversion |
| q1_status | output | 3 | Queue 1 status code |
| q2_status | output | 3 | Queue 2 status code |
| q1_overrun | output | 1 | Queue 1 trigger overrun, sticky |
| q2_overrun | output | 1 | Queue 2 trigger overrun, sticky |

## Verification
The bench attacks the preemption cycle in which a queue 1 trigger and a done pulse for queue 2 arrive together. A design that let the done through would resume queue 2 one index too far. It also checks both resume policies. A swapped policy returns queue 2 to the wrong index after queue 1 completes. Simultaneous triggers, pending-to-active handover after a pause, and re-triggering a paused queue are exercised. A design that restarted from the first index on every trigger would repeat commands. A design that counted an ordinary re-trigger as an overrun would raise the flag falsely.

// File: rtl/cqs_pkg.sv
package cqs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_PAUSE = 3'd2,
    ST_SUSP  = 3'd3,
    ST_PEND  = 3'd4,
    ST_DONE  = 3'd5
  } qstat_e;
  localparam int STAT_W = 3;
endpackage

// File: rtl/cqs_queue.sv
module cqs_queue
  import cqs_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             blocked,
  input  logic             preempt,
  input  logic             done,
  input  logic             last_pause,
  input  logic             resume_cur,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] last_idx,
  output qstat_e           st_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic             ovr_o
);
  qstat_e           st_q, st_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             ovr_q, ovr_d;

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    ovr_d = ovr_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (trig) begin
          ptr_d = first_idx;
          st_d  = blocked ? ST_PEND : ST_RUN;
        end
      end
      ST_PAUSE: begin
        if (trig) st_d = blocked ? ST_PEND : ST_RUN;
      end
      ST_PEND, ST_SUSP: begin
        if (trig)     ovr_d = 1'b1;
        if (!blocked) st_d  = ST_RUN;
      end
      ST_RUN: begin
        if (trig) ovr_d = 1'b1;
        if (preempt) begin
          st_d = ST_SUSP;
          if (!resume_cur) ptr_d = first_idx;
        end else if (done) begin
          if (ptr_q == last_idx) begin
            st_d = ST_DONE;
          end else begin
            ptr_d = ptr_q + 1'b1;
            if (last_pause) st_d = ST_PAUSE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      ovr_q <= ovr_d;
    end
  end

  assign st_o  = st_q;
  assign ptr_o = ptr_q;
  assign ovr_o = ovr_q;

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_q inside {ST_IDLE, ST_RUN, ST_PAUSE, ST_SUSP, ST_PEND, ST_DONE});
  p_pend_leaves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PEND && !blocked) |=> st_q == ST_RUN);
endmodule

// File: rtl/cqs_issue.sv
module cqs_issue
  import cqs_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qstat_e           hi_st,
  input  qstat_e           lo_st,
  input  logic [IDX_W-1:0] hi_ptr,
  input  logic [IDX_W-1:0] lo_ptr,
  input  logic             hi_trig,
  input  logic             conv_done,
  output logic             hi_done,
  output logic             lo_done,
  output logic             lo_preempt,
  output logic             lo_blocked,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             cmd_abort
);
  logic hi_run, lo_run;

  always_comb begin
    hi_run     = (hi_st == ST_RUN);
    lo_run     = (lo_st == ST_RUN);
    cmd_valid  = hi_run | lo_run;
    cmd_idx    = hi_run ? hi_ptr : lo_ptr;
    hi_done    = conv_done & hi_run;
    lo_done    = conv_done & lo_run & ~hi_run;
    lo_preempt = hi_trig & lo_run;
    lo_blocked = hi_run | hi_trig;
    cmd_abort  = lo_preempt;
  end

  p_one_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_st == ST_RUN && lo_st == ST_RUN));
  p_abort_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !cmd_abort);
endmodule

// File: rtl/cqs_sched.sv
module cqs_sched
  import cqs_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q1_trig,
  input  logic             q2_trig,
  input  logic [IDX_W-1:0] q1_first,
  input  logic [IDX_W-1:0] q1_last,
  input  logic [IDX_W-1:0] q2_first,
  input  logic [IDX_W-1:0] q2_last,
  input  logic             q2_resume_cur,
  input  logic             cmd_pause,
  input  logic             conv_done,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_idx,
  output logic             cmd_abort,
  output logic [2:0]       q1_status,
  output logic [2:0]       q2_status,
  output logic             q1_overrun,
  output logic             q2_overrun
);
  qstat_e           hi_st, lo_st;
  logic [IDX_W-1:0] hi_ptr, lo_ptr;
  logic             hi_done, lo_done, lo_preempt, lo_blocked;

  cqs_queue #(.IDX_W(IDX_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .trig(q1_trig), .blocked(1'b0), .preempt(1'b0),
    .done(hi_done), .last_pause(cmd_pause), .resume_cur(1'b0),
    .first_idx(q1_first), .last_idx(q1_last),
    .st_o(hi_st), .ptr_o(hi_ptr), .ovr_o(q1_overrun)
  );

  cqs_queue #(.IDX_W(IDX_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .trig(q2_trig), .blocked(lo_blocked),
    .preempt(lo_preempt), .done(lo_done), .last_pause(cmd_pause),
    .resume_cur(q2_resume_cur), .first_idx(q2_first), .last_idx(q2_last),
    .st_o(lo_st), .ptr_o(lo_ptr), .ovr_o(q2_overrun)
  );

  cqs_issue #(.IDX_W(IDX_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .hi_st(hi_st), .lo_st(lo_st),
    .hi_ptr(hi_ptr), .lo_ptr(lo_ptr), .hi_trig(q1_trig), .conv_done(conv_done),
    .hi_done(hi_done), .lo_done(lo_done), .lo_preempt(lo_preempt),
    .lo_blocked(lo_blocked), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
    .cmd_abort(cmd_abort)
  );

  assign q1_status = hi_st;
  assign q2_status = lo_st;

  p_abort_suspends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> q2_status == ST_SUSP);
  p_trig_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_trig && (q1_status == ST_IDLE || q1_status == ST_DONE))
      |=> (q1_status == ST_RUN && cmd_idx == $past(q1_first)));
  p_tie_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_trig && q2_trig && q1_status == ST_IDLE && q2_status == ST_IDLE)
      |=> (q1_status == ST_RUN && q2_status == ST_PEND));
endmodule

// File: tb/sim_cqs_sched.sv
module sim_cqs_sched;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         t1 = 0, t2 = 0, pz = 0, dn = 0, rs = 0;
  logic [W-1:0] f1 = 6'd2, l1 = 6'd5, f2 = 6'd10, l2 = 6'd13;
  logic         vld, ab, o1, o2;
  logic [W-1:0] idx;
  logic [2:0]   s1, s2;
  int           n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cqs_sched #(.IDX_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .q1_trig(t1), .q2_trig(t2),
    .q1_first(f1), .q1_last(l1), .q2_first(f2), .q2_last(l2),
    .q2_resume_cur(rs), .cmd_pause(pz), .conv_done(dn),
    .cmd_valid(vld), .cmd_idx(idx), .cmd_abort(ab),
    .q1_status(s1), .q2_status(s2), .q1_overrun(o1), .q2_overrun(o2)
  );

  typedef struct packed {
    logic t1, t2, pz, dn, rs;
    logic ab;
    logic vld;
    logic [5:0] idx;
    logic [2:0] s1, s2;
    logic o1, o2;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0,0, 0, 1,6'd2, 3'd1,3'd0, 0,0, 4'd2},  // R2 start q1
    '{0,0,0,1,0, 0, 1,6'd3, 3'd1,3'd0, 0,0, 4'd2},  // R2 advance
    '{0,1,0,0,0, 0, 1,6'd3, 3'd1,3'd4, 0,0, 4'd5},  // R5 pending
    '{0,1,0,0,0, 0, 1,6'd3, 3'd1,3'd4, 0,1, 4'd7},  // R7 overrun when pending
    '{0,0,0,1,0, 0, 1,6'd4, 3'd1,3'd4, 0,1, 4'd2},  // R2
    '{0,0,1,1,0, 0, 0,6'd0, 3'd2,3'd4, 0,1, 4'd4},  // R4 pause
    '{0,0,0,0,0, 0, 1,6'd10,3'd2,3'd1, 0,1, 4'd5},  // R5 handover
    '{0,0,0,1,0, 0, 1,6'd11,3'd2,3'd1, 0,1, 4'd2},  // R2
    '{1,0,0,1,1, 1, 1,6'd5, 3'd1,3'd3, 0,1, 4'd8},  // R8 abort, done ignored; R11
    '{0,0,0,1,0, 0, 0,6'd0, 3'd5,3'd3, 0,1, 4'd3},  // R3 q1 complete
    '{0,0,0,0,0, 0, 1,6'd11,3'd5,3'd1, 0,1, 4'd9},  // R9 repeat aborted, R10
    '{0,0,0,1,0, 0, 1,6'd12,3'd5,3'd1, 0,1, 4'd2},
    '{0,0,0,1,0, 0, 1,6'd13,3'd5,3'd1, 0,1, 4'd2},
    '{0,0,0,1,0, 0, 0,6'd0, 3'd5,3'd5, 0,1, 4'd3},  // R3 q2 complete
    '{1,1,0,0,0, 0, 1,6'd2, 3'd1,3'd4, 0,1, 4'd6},  // R6 tie
    '{1,0,0,0,0, 0, 1,6'd2, 3'd1,3'd4, 1,1, 4'd7},  // R7 q1 overrun
    '{0,0,0,1,0, 0, 1,6'd3, 3'd1,3'd4, 1,1, 4'd2},
    '{0,0,0,1,0, 0, 1,6'd4, 3'd1,3'd4, 1,1, 4'd2},
    '{0,0,0,1,0, 0, 1,6'd5, 3'd1,3'd4, 1,1, 4'd2},
    '{0,0,0,1,0, 0, 0,6'd0, 3'd5,3'd4, 1,1, 4'd3},  // R3
    '{0,0,0,0,0, 0, 1,6'd10,3'd5,3'd1, 1,1, 4'd5},  // R5 restart from first
    '{0,0,0,1,0, 0, 1,6'd11,3'd5,3'd1, 1,1, 4'd2},
    '{1,0,0,0,0, 1, 1,6'd2, 3'd1,3'd3, 1,1, 4'd8},  // R8, policy 0
    '{0,0,0,1,0, 0, 1,6'd3, 3'd1,3'd3, 1,1, 4'd2},
    '{0,0,0,1,0, 0, 1,6'd4, 3'd1,3'd3, 1,1, 4'd2},
    '{0,0,0,1,0, 0, 1,6'd5, 3'd1,3'd3, 1,1, 4'd2},
    '{0,0,0,1,0, 0, 0,6'd0, 3'd5,3'd3, 1,1, 4'd3},
    '{0,0,0,0,0, 0, 1,6'd10,3'd5,3'd1, 1,1, 4'd9}   // R9 restart at first, R10
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic a, b, c, d, e);
    @(negedge clk);
    t1 = a; t2 = b; pz = c; dn = d; rs = e;
    @(posedge clk); #1;
    t1 = 0; t2 = 0; pz = 0; dn = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset", {vld, ab, s1, s2, o1, o2}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      t1 = VEC[i].t1; t2 = VEC[i].t2; pz = VEC[i].pz; dn = VEC[i].dn; rs = VEC[i].rs;
      #1;
      n_chk++;
      if (ab !== VEC[i].ab) begin
        n_bad++;
        $display("FAIL R%0d vec %0d abort actual=%0d expected=%0d", VEC[i].req, i, ab, VEC[i].ab);
      end
      @(posedge clk); #1;
      n_chk++;
      if (vld !== VEC[i].vld || s1 !== VEC[i].s1 || s2 !== VEC[i].s2 ||
          o1 !== VEC[i].o1 || o2 !== VEC[i].o2 || (VEC[i].vld && idx !== VEC[i].idx)) begin
        n_bad++;
        $display("FAIL R%0d vec %0d actual vld=%0d idx=%0d s1=%0d s2=%0d o1=%0d o2=%0d expected vld=%0d idx=%0d s1=%0d s2=%0d o1=%0d o2=%0d",
                 VEC[i].req, i, vld, idx, s1, s2, o1, o2,
                 VEC[i].vld, VEC[i].idx, VEC[i].s1, VEC[i].s2, VEC[i].o1, VEC[i].o2);
      end
    end
    t1 = 0; t2 = 0; pz = 0; dn = 0; rs = 0;

    // R7 and R8: overrun while suspended, abort lasts one cycle
    do_reset();
    #1;
    chk("R1 reset again", {vld, s1, s2, o1, o2}, 0);
    step(0, 1, 0, 0, 0);
    chk("R2 q2 start idx", idx, 10);
    @(negedge clk); t1 = 1; #1;
    chk("R8 abort raised", ab, 1);
    @(negedge clk); #1;
    chk("R8 abort single cycle", ab, 0);
    @(negedge clk); t1 = 0;
    step(0, 1, 0, 0, 0);
    chk("R7 overrun while suspended", o2, 1);
    chk("R8 q2 suspended", s2, 3);

    // R4: paused q2 continues from the following index on re-trigger
    do_reset();
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0);
    chk("R4 q2 paused", s2, 2);
    chk("R4 no issue while paused", vld, 0);
    step(0, 1, 0, 0, 0);
    chk("R4 continue index", idx, 11);
    chk("R4 no false overrun", o2, 0);
    chk("R11 q2 owns", s2, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule